// File: doc/BRIEF.md
# Receive Sync and Frame Delimiter Detector

This block sits behind a clock-recovery stage and watches the recovered receive bit stream one qualified bit at a time. While reception is enabled it hunts for a programmable sync word. It declares synchronisation once a programmable number of matching words have arrived back to back on word boundaries. It then hunts for a programmable frame delimiter of up to 32 bits and, once that is seen, forwards every following bit as user data.

A timeout counter, clocked by the block's oversampling clock, starts when reception is enabled. If synchronisation is not reached within the programmed limit, it raises a sync-done flag and an interrupt. An external noise or long-run indication seen before synchronisation ends the hunt for the rest of the reception. Dropping the receive enable ends the reception and clears every flag.

Top module: `sfd_detect`

## Requirements
- R1: The sync word length code n selects n+1 bits. A word matches when the last n+1 received bits equal `sync_pat[n:0]`, and the earliest of those bits is compared with `sync_pat[n]`. The upper pattern bits are ignored, and no match is possible before n+1 bits have been received.
- R2: `sync_ok` rises after k+1 consecutive matching words, where k is `sync_need_code`. The first word may be found at any bit alignment, and each later word must complete exactly n+1 bits after the previous one. With k = 0 a single word is enough.
- R3: A word boundary whose word does not match discards the words counted so far, and the hunt resumes at any bit alignment.
- R4: Once set, `sync_ok` stays high, whatever bits follow, until `rx_en` goes low. It is low one clock after `rx_en` is seen low.
- R5: After synchronisation, `frm_ok` rises when the last m+1 bits received since synchronisation equal `dlm_pat[m:0]`, where m is `dlm_len_code`. The earliest of those bits is compared with `dlm_pat[m]`. `frm_ok` is never high without `sync_ok`, and it stays high until `rx_en` goes low.
- R6: With `allow_err` = 0 the delimiter must match exactly. With `allow_err` = 1 a window differing in exactly one bit also counts as a match. A window differing in two bits never matches.
- R7: Each qualified bit received after `frm_ok` is set appears on `data_bit` with `data_vld` high one clock later. The bits up to and including the last delimiter bit never raise `data_vld`.
- R8: With `rx_en` held high and no synchronisation, `sydn` and `irq` rise on the (L+1)-th clock edge with `rx_en` high, where L is `time_limit`. Once `sync_ok` is high the counter stops and `sydn` does not rise.
- R9: `sydn` and `irq` are low one clock after `rx_en` is seen low.
- R10: A high `noise_flag` or `long_flag` during a reception, before synchronisation, stops the sync hunt. Matching words arriving afterwards do not raise `sync_ok` until `rx_en` has gone low and high again.
- R11: While `rst_n` is low all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Reception enable; low ends a reception and clears the flags |
| bit_vld | input | 1 | Qualifies `bit_in` for one clock |
| bit_in | input | 1 | Recovered receive bit |
| sync_pat | input | SW_MAX | Sync word pattern |
| sync_len_code | input | log2(SW_MAX) | Sync word length minus one |
| sync_need_code | input | NSW_W | Required consecutive sync words minus one |
| dlm_pat | input | DLM_MAX | Frame delimiter pattern |
| dlm_len_code | input | log2(DLM_MAX) | Delimiter length minus one |
| allow_err | input | 1 | Accept a single bit error in the delimiter |
| time_limit | input | TMR_W | Sync timeout in clocks |
| noise_flag | input | 1 | External noise indication |
| long_flag | input | 1 | External long-run indication |
| sync_ok | output | 1 | Synchronisation achieved |
| frm_ok | output | 1 | Frame delimiter found |
| sydn | output | 1 | Sync timeout expired |
| irq | output | 1 | Interrupt request, active high |
| data_vld | output | 1 | Qualifies `data_bit` |
| data_bit | output | 1 | User data bit |

## Verification
The hardest state to reach from the ports is a restart in the middle of counting. Several words must already have matched on their boundaries, and the following word must then fail without any sliding window across the failed word or the next prefix happening to match the pattern. The stimulus uses a pattern with no self-overlapping rotation and an all-zero corrupt word, so the only later match falls exactly on the next boundary. A near-miss delimiter is also delicate, because a tolerant comparator could accept an earlier window. The bench therefore sends the delimiter immediately after synchronisation, so the single flipped bit or the two flipped bits fall within the one window that can fill.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   typedef enum logic [1:0] {
      HS_HUNT  = 2'd0,
      HS_COUNT = 2'd1,
      HS_LOCK  = 2'd2
   } hunt_st_t;
endpackage

// File: rtl/sfd_sync_hunt.sv
module sfd_sync_hunt
   import sfd_pkg::*;
#(
   parameter int SW_MAX = 8,
   parameter int NSW_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       en,
   input  logic                       bit_vld,
   input  logic                       bit_in,
   input  logic [SW_MAX-1:0]          pat,
   input  logic [$clog2(SW_MAX)-1:0]  len_code,
   input  logic [NSW_W-1:0]           need_code,
   output logic                       locked
);
   localparam int LEN_W  = $clog2(SW_MAX);
   localparam int FILL_W = $clog2(SW_MAX + 1);
   localparam int WRD_W  = NSW_W + 1;

   hunt_st_t             st;
   logic [SW_MAX-1:0]    sh, nxt, mask;
   logic [FILL_W-1:0]    fill, fill_nxt, len;
   logic [LEN_W-1:0]     phase;
   logic [WRD_W-1:0]     words;
   logic                 win_ok, boundary;

   assign len      = FILL_W'(len_code) + FILL_W'(1);
   assign nxt      = {sh[SW_MAX-2:0], bit_in};
   assign fill_nxt = (fill == FILL_W'(SW_MAX)) ? fill : fill + FILL_W'(1);
   assign boundary = (phase == len_code);

   always_comb begin
      for (int i = 0; i < SW_MAX; i++) mask[i] = (i < int'(len));
   end

   assign win_ok = (((nxt ^ pat) & mask) == '0) && (fill_nxt >= len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= HS_HUNT;
         sh    <= '0;
         fill  <= '0;
         phase <= '0;
         words <= '0;
      end else if (clr) begin
         st    <= HS_HUNT;
         sh    <= '0;
         fill  <= '0;
         phase <= '0;
         words <= '0;
      end else if (en && bit_vld && st != HS_LOCK) begin
         sh   <= nxt;
         fill <= fill_nxt;
         if (st == HS_HUNT) begin
            if (win_ok) begin
               if (need_code == '0) st <= HS_LOCK;
               else begin
                  st    <= HS_COUNT;
                  words <= WRD_W'(1);
                  phase <= '0;
               end
            end
         end else begin
            if (boundary) begin
               phase <= '0;
               if (!win_ok) st <= HS_HUNT;
               else if (words == WRD_W'(need_code)) st <= HS_LOCK;
               else words <= words + WRD_W'(1);
            end else begin
               phase <= phase + LEN_W'(1);
            end
         end
      end
   end

   assign locked = (st == HS_LOCK);

   AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == HS_COUNT) |-> (words != '0 && words <= WRD_W'(need_code))); // R2
   AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(bit_vld && en)); // R2
endmodule

// File: rtl/sfd_dlm_match.sv
module sfd_dlm_match #(
   parameter int DLM_MAX = 32,
   parameter bit TOL_EN  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        arm,
   input  logic                        bit_vld,
   input  logic                        bit_in,
   input  logic [DLM_MAX-1:0]          pat,
   input  logic [$clog2(DLM_MAX)-1:0]  len_code,
   input  logic                        allow_err,
   output logic                        found
);
   localparam int FILL_W = $clog2(DLM_MAX + 1);

   logic [DLM_MAX-1:0] sh, nxt, mask, diff;
   logic [FILL_W-1:0]  fill, fill_nxt, len;
   logic               dist_ok, filled;

   assign len      = FILL_W'(len_code) + FILL_W'(1);
   assign nxt      = {sh[DLM_MAX-2:0], bit_in};
   assign fill_nxt = (fill == FILL_W'(DLM_MAX)) ? fill : fill + FILL_W'(1);
   assign filled   = (fill_nxt >= len);

   always_comb begin
      for (int i = 0; i < DLM_MAX; i++) mask[i] = (i < int'(len));
   end

   assign diff = (nxt ^ pat) & mask;

   generate
      if (TOL_EN) begin : g_tol
         assign dist_ok = (diff == '0) ||
                          (allow_err && ((diff & (diff - DLM_MAX'(1))) == '0));
      end else begin : g_exact
         logic unused_allow;
         assign unused_allow = allow_err;
         assign dist_ok = (diff == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         fill  <= '0;
         found <= 1'b0;
      end else if (clr) begin
         sh    <= '0;
         fill  <= '0;
         found <= 1'b0;
      end else if (arm && bit_vld && !found) begin
         sh   <= nxt;
         fill <= fill_nxt;
         if (filled && dist_ok) found <= 1'b1;
      end
   end

   AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !clr) |=> found); // R5
   AST_FRM_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> $past(arm)); // R5
endmodule

// File: rtl/sfd_timeout.sv
module sfd_timeout #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             run,
   input  logic [TMR_W-1:0] limit,
   output logic             expired
);
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!rx_en) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (run && !expired) begin
         if (cnt == limit) expired <= 1'b1;
         else cnt <= cnt + TMR_W'(1);
      end
   end

   AST_TMR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !run) |=> (!rx_en || ($stable(cnt) && $stable(expired)))); // R8
   AST_SYDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !expired); // R9
endmodule

// File: rtl/sfd_detect.sv
module sfd_detect #(
   parameter int SW_MAX  = 8,
   parameter int NSW_W   = 3,
   parameter int DLM_MAX = 32,
   parameter int TMR_W   = 16,
   parameter bit TOL_EN  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_en,
   input  logic                        bit_vld,
   input  logic                        bit_in,
   input  logic [SW_MAX-1:0]           sync_pat,
   input  logic [$clog2(SW_MAX)-1:0]   sync_len_code,
   input  logic [NSW_W-1:0]            sync_need_code,
   input  logic [DLM_MAX-1:0]          dlm_pat,
   input  logic [$clog2(DLM_MAX)-1:0]  dlm_len_code,
   input  logic                        allow_err,
   input  logic [TMR_W-1:0]            time_limit,
   input  logic                        noise_flag,
   input  logic                        long_flag,
   output logic                        sync_ok,
   output logic                        frm_ok,
   output logic                        sydn,
   output logic                        irq,
   output logic                        data_vld,
   output logic                        data_bit
);
   generate
      if (SW_MAX < 2 || (1 << $clog2(SW_MAX)) != SW_MAX) begin : g_bad_sw
         $error("SW_MAX must be a power of two of at least 2");
      end
      if (DLM_MAX < 2 || (1 << $clog2(DLM_MAX)) != DLM_MAX) begin : g_bad_dlm
         $error("DLM_MAX must be a power of two of at least 2");
      end
      if (NSW_W < 1 || TMR_W < 1) begin : g_bad_w
         $error("NSW_W and TMR_W must be at least 1");
      end
   endgenerate

   logic stop_q, search_en, clr;

   assign clr       = !rx_en;
   assign search_en = !stop_q && !noise_flag && !long_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else if (!rx_en) stop_q <= 1'b0;
      else if ((noise_flag || long_flag) && !sync_ok) stop_q <= 1'b1;
   end

   sfd_sync_hunt #(.SW_MAX(SW_MAX), .NSW_W(NSW_W)) u_hunt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(search_en),
      .bit_vld(bit_vld), .bit_in(bit_in), .pat(sync_pat),
      .len_code(sync_len_code), .need_code(sync_need_code), .locked(sync_ok)
   );

   sfd_dlm_match #(.DLM_MAX(DLM_MAX), .TOL_EN(TOL_EN)) u_dlm (
      .clk(clk), .rst_n(rst_n), .clr(clr), .arm(sync_ok),
      .bit_vld(bit_vld), .bit_in(bit_in), .pat(dlm_pat),
      .len_code(dlm_len_code), .allow_err(allow_err), .found(frm_ok)
   );

   sfd_timeout #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .run(!sync_ok),
      .limit(time_limit), .expired(sydn)
   );

   assign irq = sydn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_vld <= 1'b0;
         data_bit <= 1'b0;
      end else if (!rx_en) begin
         data_vld <= 1'b0;
         data_bit <= 1'b0;
      end else begin
         data_vld <= bit_vld && frm_ok;
         data_bit <= bit_in;
      end
   end

   AST_FRM_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ok |-> sync_ok); // R5
   AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      data_vld |-> $past(frm_ok)); // R7
   AST_STOP_BLOCKS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !sync_ok) |=> !sync_ok); // R10
   AST_NO_SYDN_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && !sydn) |=> !sydn); // R8
   AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!sync_ok && !frm_ok && !data_vld)); // R4
endmodule

// File: tb/sfd_detect_bench.sv
module sfd_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        bit_vld = 1'b0;
   logic        bit_in = 1'b0;
   logic [7:0]  sync_pat = 8'hA5;
   logic [2:0]  sync_len_code = 3'd7;
   logic [2:0]  sync_need_code = 3'd0;
   logic [31:0] dlm_pat = 32'hFFFF_FC3A;
   logic [4:0]  dlm_len_code = 5'd11;
   logic        allow_err = 1'b0;
   logic [15:0] time_limit = 16'hFFFF;
   logic        noise_flag = 1'b0;
   logic        long_flag = 1'b0;
   logic        sync_ok, frm_ok, sydn, irq, data_vld, data_bit;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sfd_detect u_sfd_detect (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
      .sync_pat(sync_pat), .sync_len_code(sync_len_code), .sync_need_code(sync_need_code),
      .dlm_pat(dlm_pat), .dlm_len_code(dlm_len_code), .allow_err(allow_err),
      .time_limit(time_limit), .noise_flag(noise_flag), .long_flag(long_flag),
      .sync_ok(sync_ok), .frm_ok(frm_ok), .sydn(sydn), .irq(irq),
      .data_vld(data_vld), .data_bit(data_bit)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_in  = v[i];
      end
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_chk(input logic b);
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = b;
      @(negedge clk);
      bit_vld = 1'b0;
      chk("R7 data_vld after frame", data_vld, 1'b1);
      chk("R7 data_bit after frame", data_bit, b);
   endtask

   task automatic stop_rx;
      @(negedge clk);
      rx_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic start_rx;
      rx_en = 1'b1;
   endtask

   task automatic t_reset;
      chk("R11 sync_ok in reset", sync_ok, 1'b0);
      chk("R11 frm_ok in reset", frm_ok, 1'b0);
      chk("R11 sydn in reset", sydn, 1'b0);
      chk("R11 irq in reset", irq, 1'b0);
      chk("R11 data_vld in reset", data_vld, 1'b0);
   endtask

   task automatic t_short_word;
      stop_rx();
      sync_pat = 8'hF6; sync_len_code = 3'd3; sync_need_code = 3'd0;
      start_rx();
      send(32'b011, 3);
      chk("R1 partial word no sync", sync_ok, 1'b0);
      send(32'b0, 1);
      chk("R1 four bit word sync", sync_ok, 1'b1);
      stop_rx();
   endtask

   task automatic t_multi;
      sync_pat = 8'hA5; sync_len_code = 3'd7; sync_need_code = 3'd2;
      start_rx();
      send(32'hA5A5, 16);
      chk("R2 two of three words", sync_ok, 1'b0);
      send(32'hA5, 8);
      chk("R2 three words sync", sync_ok, 1'b1);
      stop_rx();
   endtask

   task automatic t_restart;
      start_rx();
      send(32'hA5A5, 16);
      send(32'h00, 8);
      send(32'hA5A5, 16);
      chk("R3 count restarted", sync_ok, 1'b0);
      send(32'hA5, 8);
      chk("R3 sync after restart", sync_ok, 1'b1);
      send(32'h00, 8);
      chk("R4 sync holds on garbage", sync_ok, 1'b1);
      stop_rx();
      chk("R4 sync clears on rx_en low", sync_ok, 1'b0);
   endtask

   task automatic t_dlm_exact;
      sync_need_code = 3'd0; allow_err = 1'b0;
      start_rx();
      send(32'hA5, 8);
      chk("R2 single word sync", sync_ok, 1'b1);
      send(32'hC3A ^ 32'h010, 12);
      chk("R6 exact rejects one error", frm_ok, 1'b0);
      stop_rx();
      start_rx();
      send(32'hA5, 8);
      send(32'hC3A >> 1, 11);
      chk("R5 partial delimiter", frm_ok, 1'b0);
      send(32'h0, 1);
      chk("R5 delimiter found", frm_ok, 1'b1);
      chk("R7 no data for delimiter bit", data_vld, 1'b0);
      send_chk(1'b1);
      send_chk(1'b0);
      send_chk(1'b1);
      send_chk(1'b1);
      send_chk(1'b0);
      chk("R5 frm holds", frm_ok, 1'b1);
      stop_rx();
      chk("R5 frm clears on rx_en low", frm_ok, 1'b0);
   endtask

   task automatic t_dlm_tol;
      allow_err = 1'b1;
      start_rx();
      send(32'hA5, 8);
      send(32'hC3A ^ 32'h010, 12);
      chk("R6 tolerant accepts one error", frm_ok, 1'b1);
      stop_rx();
      start_rx();
      send(32'hA5, 8);
      send(32'hC3A ^ 32'h011, 12);
      chk("R6 tolerant rejects two errors", frm_ok, 1'b0);
      stop_rx();
      allow_err = 1'b0;
   endtask

   task automatic t_noise;
      start_rx();
      @(negedge clk); noise_flag = 1'b1;
      @(negedge clk); noise_flag = 1'b0;
      send(32'hA5, 8);
      chk("R10 noise stops hunt", sync_ok, 1'b0);
      stop_rx();
      start_rx();
      @(negedge clk); long_flag = 1'b1;
      @(negedge clk); long_flag = 1'b0;
      send(32'hA5A5, 16);
      chk("R10 long run stops hunt", sync_ok, 1'b0);
      stop_rx();
      start_rx();
      send(32'hA5, 8);
      chk("R10 new reception hunts again", sync_ok, 1'b1);
      stop_rx();
   endtask

   task automatic t_timeout;
      time_limit = 16'd20;
      start_rx();
      repeat (20) @(negedge clk);
      chk("R8 sydn not yet", sydn, 1'b0);
      @(negedge clk);
      chk("R8 sydn at limit", sydn, 1'b1);
      chk("R8 irq at limit", irq, 1'b1);
      chk("R8 no sync", sync_ok, 1'b0);
      stop_rx();
      chk("R9 sydn cleared", sydn, 1'b0);
      chk("R9 irq cleared", irq, 1'b0);
   endtask

   task automatic t_freeze;
      time_limit = 16'd30;
      start_rx();
      send(32'hA5, 8);
      chk("R8 sync before limit", sync_ok, 1'b1);
      repeat (40) @(negedge clk);
      chk("R8 timer frozen after sync", sydn, 1'b0);
      chk("R8 irq quiet after sync", irq, 1'b0);
      stop_rx();
      time_limit = 16'hFFFF;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_short_word();
      t_multi();
      t_restart();
      t_dlm_exact();
      t_dlm_tol();
      t_noise();
      t_timeout();
      t_freeze();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #500us;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule